// File: doc/BRIEF.md
# Concurrent Timed Execution Slots with Tagged Result Broadcast

This block holds a small pool of execution slots that sit behind an in-order dispatcher. Each dispatch names one slot and carries an operation code, two ready operands and the tag of the station that owns the result. The slot computes the result at once with a simple integer stand-in. It then starts a countdown whose length depends on the operation: short for add, subtract and load, longer for multiply and much longer for divide. Every slot counts on its own, so a short operation dispatched after a long one can finish first.

Finished results leave through one shared broadcast bus. The bus carries a 64-bit value and the 4-bit tag of the producer, so any listener can match on the source. The bus carries one result per cycle. When several countdowns reach zero together, the slot that was dispatched earliest wins. The others keep their values until they get the bus. A slot raises its completion acknowledge, and becomes free, only in the cycle its own result is on the bus.

Top module: `fu_bcast_pool`

## Requirements
- R1: Op code 0 (add) returns a+b, op code 1 (subtract) returns a-b and op code 4 (load) returns operand a unchanged, all modulo 2^64. Each becomes eligible for the bus 2 cycles after the clock edge that accepted it. Op codes 5 to 7 behave like add.
- R2: Op code 2 (multiply) returns the low 64 bits of a*b and becomes eligible 10 cycles after acceptance.
- R3: Op code 3 (divide) returns the unsigned quotient a/b and becomes eligible 40 cycles after acceptance. A zero divisor yields all ones.
- R4: While a result is broadcast, cdb_valid_o is 1 and cdb_tag_o equals the tag given with that dispatch. While nothing is broadcast, cdb_valid_o, cdb_tag_o and cdb_data_o are all zero.
- R5: At most one result is broadcast per cycle. Among eligible slots, the one accepted earliest goes first. Every other eligible slot keeps its result and goes in a later cycle, and the bus is never idle while any slot is eligible.
- R6: done_o bit s is 1 only in the cycle slot s is on the bus, so done_o is zero or one-hot. The slot can accept a new dispatch from the next cycle on.
- R7: All slots count down at the same time. Several loads or other operations may be in flight at once, and completion order follows the countdowns rather than dispatch order.
- R8: A dispatch to a slot that is still busy is ignored. The pending result, tag, timing and age of that slot are unchanged.
- R9: After reset all slots are free, cdb_valid_o is 0 and done_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| disp_valid_i | input | 1 | Dispatch request this cycle |
| disp_slot_i | input | 2 | Target slot index |
| disp_op_i | input | 3 | Operation code (0 add, 1 sub, 2 mul, 3 div, 4 load) |
| disp_tag_i | input | 4 | Tag of the station that owns the result |
| disp_a_i | input | 64 | First operand |
| disp_b_i | input | 64 | Second operand |
| cdb_valid_o | output | 1 | A result is on the bus |
| cdb_tag_o | output | 4 | Tag of the producer of the broadcast result |
| cdb_data_o | output | 64 | Broadcast result value |
| done_o | output | 4 | Per-slot completion acknowledge, one-hot or zero |

## Verification
Two countdowns can expire in the same cycle, and then the arbitration between them decides who goes first. The bench sets this up on purpose. It staggers the dispatches so that a divide, a multiply and a short operation all reach zero on the same edge, with a load following one cycle later. It then checks that they leave the bus one per cycle in dispatch-age order. A dispatch into a slot that is still occupied can also land in the same cycle as that slot's countdown or broadcast. A long pseudo-random run provokes this often. Each cycle, every bus and acknowledge value is compared with a cycle-exact model that the bench derives from the latencies and the age rule.

// File: rtl/fu_pkg.sv
package fu_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_MUL  = 3'd2,
    OP_DIV  = 3'd3,
    OP_LOAD = 3'd4
  } fu_op_e;
endpackage

// File: rtl/fu_alu.sv
module fu_alu #(
  parameter int DATA_W = 64
) (
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  import fu_pkg::*;

  always_comb begin
    case (op_i)
      OP_SUB:  res_o = a_i - b_i;
      OP_MUL:  res_o = a_i * b_i;
      OP_DIV:  res_o = (b_i == '0) ? '1 : a_i / b_i; // R3: no stall on zero divisor
      OP_LOAD: res_o = a_i;
      default: res_o = a_i + b_i;
    endcase
  end
endmodule

// File: rtl/fu_slot.sv
module fu_slot #(
  parameter int DATA_W    = 64,
  parameter int TAG_W     = 4,
  parameter int CNT_W     = 6,
  parameter int LAT_SHORT = 2,
  parameter int LAT_MUL   = 10,
  parameter int LAT_DIV   = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic              grant_i,
  output logic              busy_o,
  output logic              ready_o,
  output logic [DATA_W-1:0] res_o,
  output logic [TAG_W-1:0]  tag_o
);
  import fu_pkg::*;

  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q, lat;
  logic [DATA_W-1:0] res_q;
  logic [TAG_W-1:0]  tag_q;

  always_comb begin
    case (op_i)
      OP_MUL:  lat = CNT_W'(LAT_MUL);
      OP_DIV:  lat = CNT_W'(LAT_DIV);
      default: lat = CNT_W'(LAT_SHORT);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      res_q  <= '0;
      tag_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= lat;
      res_q  <= res_i;
      tag_q  <= tag_i;
    end else begin
      if (grant_i) busy_q <= 1'b0;
      if (busy_q && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o  = busy_q;
  assign ready_o = busy_q && (cnt_q == '0);
  assign res_o   = res_q;
  assign tag_o   = tag_q;

  // checker state: cycles since acceptance and latency chosen then
  logic [CNT_W-1:0] chk_el_q, chk_lat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_el_q  <= '0;
      chk_lat_q <= '0;
    end else if (start_i) begin
      chk_el_q  <= '0;
      chk_lat_q <= lat;
    end else if (busy_q && !ready_o) begin
      chk_el_q  <= chk_el_q + 1'b1;
    end
  end

  // R1 R2 R3: eligibility arrives exactly after the op latency
  assert_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> chk_el_q == chk_lat_q);
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !grant_i |=> busy_q && $stable(res_q) && $stable(tag_q));
  assert_free_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |=> !busy_q);
  assert_grant_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |-> ready_o);
endmodule

// File: rtl/fu_age_arb.sv
module fu_age_arb #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] start_i,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o
);
  // older_q[j][i]: slot j was accepted before slot i
  logic [N-1:0] older_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) older_q[i] <= '0;
    end else begin
      for (int k = 0; k < N; k++) begin
        if (start_i[k]) begin
          for (int j = 0; j < N; j++) begin
            if (j != k) begin
              older_q[k][j] <= 1'b0;
              older_q[j][k] <= 1'b1;
            end
          end
        end
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_gnt
    logic [N-1:0] blk;
    always_comb begin
      for (int j = 0; j < N; j++) blk[j] = req_i[j] && older_q[j][i];
    end
    assign grant_o[i] = req_i[i] && !(|blk);
  end

  assert_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));
  assert_busy_bus_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |-> (|grant_o));
endmodule

// File: rtl/fu_bcast_pool.sv
module fu_bcast_pool #(
  parameter int NUM_SLOTS = 4,
  parameter int DATA_W    = 64,
  parameter int TAG_W     = 4,
  parameter int LAT_SHORT = 2,
  parameter int LAT_MUL   = 10,
  parameter int LAT_DIV   = 40,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int LAT_MAX  = (LAT_DIV > LAT_MUL) ?
                            ((LAT_DIV > LAT_SHORT) ? LAT_DIV : LAT_SHORT) :
                            ((LAT_MUL > LAT_SHORT) ? LAT_MUL : LAT_SHORT),
  localparam int CNT_W    = $clog2(LAT_MAX + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 disp_valid_i,
  input  logic [SLOT_W-1:0]    disp_slot_i,
  input  logic [2:0]           disp_op_i,
  input  logic [TAG_W-1:0]     disp_tag_i,
  input  logic [DATA_W-1:0]    disp_a_i,
  input  logic [DATA_W-1:0]    disp_b_i,
  output logic                 cdb_valid_o,
  output logic [TAG_W-1:0]     cdb_tag_o,
  output logic [DATA_W-1:0]    cdb_data_o,
  output logic [NUM_SLOTS-1:0] done_o
);
  logic [DATA_W-1:0]    alu_res;
  logic [NUM_SLOTS-1:0] busy, ready, accept, grant;
  logic [DATA_W-1:0]    slot_res [NUM_SLOTS];
  logic [TAG_W-1:0]     slot_tag [NUM_SLOTS];

  fu_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i (disp_op_i),
    .a_i  (disp_a_i),
    .b_i  (disp_b_i),
    .res_o(alu_res)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign accept[s] = disp_valid_i && (disp_slot_i == SLOT_W'(s)) && !busy[s];

    fu_slot #(
      .DATA_W(DATA_W), .TAG_W(TAG_W), .CNT_W(CNT_W),
      .LAT_SHORT(LAT_SHORT), .LAT_MUL(LAT_MUL), .LAT_DIV(LAT_DIV)
    ) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i(accept[s]),
      .op_i   (disp_op_i),
      .res_i  (alu_res),
      .tag_i  (disp_tag_i),
      .grant_i(grant[s]),
      .busy_o (busy[s]),
      .ready_o(ready[s]),
      .res_o  (slot_res[s]),
      .tag_o  (slot_tag[s])
    );
  end

  fu_age_arb #(.N(NUM_SLOTS)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(accept),
    .req_i  (ready),
    .grant_o(grant)
  );

  always_comb begin
    cdb_data_o = '0;
    cdb_tag_o  = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      cdb_data_o = cdb_data_o | (slot_res[s] & {DATA_W{grant[s]}});
      cdb_tag_o  = cdb_tag_o  | (slot_tag[s] & {TAG_W{grant[s]}});
    end
  end

  assign cdb_valid_o = |grant;
  assign done_o      = grant;

  assert_idle_bus_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cdb_valid_o |-> cdb_data_o == '0 && cdb_tag_o == '0);
endmodule

// File: tb/fu_bcast_pool_tb.sv
`timescale 1ns/1ps
module fu_bcast_pool_tb;
  localparam int NS = 4;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        disp_valid_i = 1'b0;
  logic [1:0]  disp_slot_i = '0;
  logic [2:0]  disp_op_i = '0;
  logic [3:0]  disp_tag_i = '0;
  logic [63:0] disp_a_i = '0, disp_b_i = '0;
  logic        cdb_valid_o;
  logic [3:0]  cdb_tag_o;
  logic [63:0] cdb_data_o;
  logic [3:0]  done_o;

  fu_bcast_pool u_dut (.*);

  always #2.5 clk_i = ~clk_i;

  int total = 0, bad = 0;
  bit finished = 0;
  string cur_req = "R9";

  // bench model
  bit          m_busy [NS];
  int          m_left [NS];
  logic [63:0] m_data [NS];
  logic [3:0]  m_tag  [NS];
  int          m_seq  [NS];
  int          seq_ctr = 0;
  int          g = -1;
  logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

  function automatic logic [63:0] exp_res(logic [2:0] op, logic [63:0] a, logic [63:0] b);
    case (op)
      3'd1: return a - b;
      3'd2: return a * b;
      3'd3: return (b == 0) ? {64{1'b1}} : a / b;
      3'd4: return a;
      default: return a + b;
    endcase
  endfunction

  function automatic int exp_lat(logic [2:0] op);
    return (op == 3'd2) ? 10 : (op == 3'd3) ? 40 : 2;
  endfunction

  task automatic chk(string what, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h t=%0t", cur_req, what, got, exp, $time);
    end
  endtask

  task automatic step(bit v, int slot, logic [2:0] op, logic [3:0] tag,
                      logic [63:0] a, logic [63:0] b);
    bit acc;
    disp_valid_i = v; disp_slot_i = 2'(slot); disp_op_i = op;
    disp_tag_i = tag; disp_a_i = a; disp_b_i = b;
    @(posedge clk_i);
    acc = v && !m_busy[slot];
    for (int s = 0; s < NS; s++) if (m_busy[s] && m_left[s] > 0) m_left[s]--;
    if (g >= 0) m_busy[g] = 0;
    if (acc) begin
      m_busy[slot] = 1; m_left[slot] = exp_lat(op);
      m_data[slot] = exp_res(op, a, b); m_tag[slot] = tag;
      m_seq[slot] = seq_ctr++;
    end
    #1;
    g = -1;
    for (int s = 0; s < NS; s++)
      if (m_busy[s] && m_left[s] == 0 && (g < 0 || m_seq[s] < m_seq[g])) g = s;
    chk("valid", 64'(cdb_valid_o), 64'(g >= 0));
    chk("done", 64'(done_o), (g >= 0) ? 64'(1) << g : 64'd0);
    chk("tag", 64'(cdb_tag_o), (g >= 0) ? 64'(m_tag[g]) : 64'd0);
    chk("data", cdb_data_o, (g >= 0) ? m_data[g] : 64'd0);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 3'd0, 4'd0, 64'd0, 64'd0);
  endtask

  task automatic drain();
    int n = 0;
    while ((m_busy[0] || m_busy[1] || m_busy[2] || m_busy[3]) && n < 300) begin
      idle(1); n++;
    end
    if (n >= 300) chk("drain", 64'd1, 64'd0);
  endtask

  function automatic logic [63:0] rnd();
    lfsr ^= lfsr << 13; lfsr ^= lfsr >> 7; lfsr ^= lfsr << 17;
    return lfsr;
  endfunction

  initial begin
    for (int s = 0; s < NS; s++) begin m_busy[s] = 0; m_left[s] = 0; m_seq[s] = 0; end
    repeat (2) @(posedge clk_i);
    #1;
    chk("reset valid R9", 64'(cdb_valid_o), 64'd0);
    chk("reset done R9", 64'(done_o), 64'd0);
    rst_ni = 1'b1;
    idle(2);

    // R1 R2 R3 R4: every op into every slot with varied operands
    for (int op = 0; op < 5; op++) begin
      cur_req = (op == 2) ? "R2" : (op == 3) ? "R3" : "R1";
      for (int s = 0; s < NS; s++) begin
        for (int p = 0; p < 4; p++) begin
          logic [63:0] a, b;
          a = (p == 0) ? 64'hFFFF_FFFF_FFFF_FFFF : rnd();
          b = (p == 1) ? 64'd0 : (p == 2) ? 64'd7 : rnd() >> (p * 8);
          step(1, s, 3'(op), 4'(op * 3 + s + p), a, b);
          drain();
        end
      end
    end

    // R3: zero divisor yields all ones
    cur_req = "R3";
    step(1, 2, 3'd3, 4'hD, 64'd12345, 64'd0);
    drain();

    // R4: tag per producer
    cur_req = "R4";
    for (int t = 0; t < 16; t++) begin step(1, t % NS, 3'd0, 4'(t), 64'(t), 64'd1); drain(); end

    // R5: divide, multiply, add expire together, load one later
    cur_req = "R5";
    step(1, 0, 3'd3, 4'h1, 64'd1000, 64'd10);
    idle(29);
    step(1, 1, 3'd2, 4'h2, 64'd6, 64'd7);
    idle(7);
    step(1, 2, 3'd0, 4'h3, 64'd5, 64'd5);
    step(1, 3, 3'd4, 4'h4, 64'hABCD, 64'd0);
    drain();

    // R7: multiple loads in flight, short op overtakes long one
    cur_req = "R7";
    step(1, 0, 3'd3, 4'h8, 64'd99, 64'd3);
    step(1, 1, 3'd4, 4'h9, 64'd11, 64'd0);
    step(1, 2, 3'd4, 4'hA, 64'd22, 64'd0);
    step(1, 3, 3'd4, 4'hB, 64'd33, 64'd0);
    drain();

    // R8: dispatch into a busy slot is ignored
    cur_req = "R8";
    step(1, 1, 3'd2, 4'h5, 64'd3, 64'd4);
    step(1, 1, 3'd0, 4'hE, 64'd100, 64'd200);
    idle(4);
    step(1, 1, 3'd1, 4'hF, 64'd1, 64'd1);
    drain();

    // R6 R5 R8: pseudo-random traffic, busy targets included
    cur_req = "R6";
    for (int i = 0; i < 4000; i++) begin
      logic [63:0] r;
      logic [2:0] op;
      r = rnd();
      op = (r[7:4] == 0) ? 3'd3 : (r[7:4] < 3) ? 3'd2 : 3'(r[10:8] % 5);
      if (r[1:0] != 0) step(1, int'(r[13:12]), op, r[19:16], rnd(), rnd() >> r[25:20]);
      else idle(1);
    end
    drain();

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule